// File: doc/BRIEF.md
# Machine Status Word Control Unit

This block keeps the processor's 16-bit machine status word and decides, for every decoded instruction, whether a coprocessor-related instruction may proceed. The instruction decoder hands it one command at a time (load the word, store the word, clear the task-switched flag, or report that the instruction is a coprocessor escape or a coprocessor wait), together with the current privilege level and a real-mode indication. The block answers with a one-cycle fault strobe carrying a vector number when the command must trap: vector 13 for a privilege violation and vector 7 when the coprocessor is not available to the instruction.

The low four bits carry meaning: bit 0 enables protected mode, bit 1 asks wait instructions to monitor the coprocessor, bit 2 requests coprocessor emulation and bit 3 records that a task switch happened. The task-switch engine sets bit 3 through a one-cycle strobe; only software can clear it. Store results leave on a valid/ready stream. While a stored word waits for `st_ready`, `cmd_ready` is low and no new command is taken; the word and `st_valid` stay unchanged until the handshake completes. Commands are taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.

Top module: `msw_ctrl`

## Requirements
- R1: After reset the status word is 0x0000, `st_valid` and `fault_valid` are low and `cmd_ready` is high.
- R2: An accepted load (op 1) in real mode or at privilege level 0 copies data bits 1 and 2 into the monitor and emulate flags on the accepting edge; bits 15..4 stay at zero and bit 3 is not touched by a load.
- R3: Protected-mode enable (bit 0) is set by a permitted load with data bit 0 high and, once set, stays set until reset, even when a load writes 0 there.
- R4: A load outside real mode at a privilege level other than 0 changes no bit and raises a fault with vector 13 one cycle after acceptance.
- R5: A store (op 2) is allowed at every privilege level; one cycle after acceptance `st_valid` rises with the word as held before that edge, and while `st_ready` is low `st_valid`, `st_data` stay put and `cmd_ready` is low, so commands offered then are ignored.
- R6: The task-switched flag (bit 3) is set by the `ts_set` strobe, visible one cycle later, and no load changes it.
- R7: A clear-task-switched command (op 3) at privilege level 0 clears bit 3; at any other level it changes no bit and raises fault vector 13.
- R8: When `ts_set` and a permitted clear-task-switched command hit the same edge, bit 3 ends up set.
- R9: A coprocessor escape (op 4) raises fault vector 7 when the emulate flag or the task-switched flag is set, and no fault otherwise.
- R10: A coprocessor wait (op 5) raises fault vector 7 only when both the monitor flag and the task-switched flag are set.
- R11: Each faulting command yields exactly one `fault_valid` cycle, one cycle after acceptance; commands that do not fault produce none. Ops 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| real_mode | input | 1 | High while the core runs in real address mode |
| cpl | input | 2 | Current privilege level |
| ts_set | input | 1 | One-cycle strobe from the task-switch engine |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (low while a store result waits) |
| cmd_op | input | 3 | 0 none, 1 load, 2 store, 3 clear task-switched, 4 escape, 5 wait |
| cmd_data | input | 16 | Load data |
| st_valid | output | 1 | Stored word available |
| st_ready | input | 1 | Consumer takes the stored word |
| st_data | output | 16 | Stored word |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_vec | output | 8 | Fault vector number |
| status_word | output | 16 | Current machine status word |

## Verification
The bench drives loads that try to clear protected-mode enable, to write the reserved bits and to write the task-switched bit; a design that let the load through would show a cleared bit 0 or nonzero high bits in the status word. It offers loads and clears at non-zero privilege both inside and outside real mode, where a wrong privilege gate shows up as a missing vector-13 fault or a changed word. It pits the hardware set strobe against a clear in the same cycle, where a design with the wrong priority leaves the flag clear, and it walks escape and wait through the flag combinations, catching a wait that faults on the task-switched flag alone. It also holds the store stream stalled and offers a load meanwhile, which a design without back-pressure would accept.

// File: rtl/msw_pkg.sv
package msw_pkg;

  // command codes from the decoder
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_CLRTS = 3'd3,
    OP_ESC   = 3'd4,
    OP_WAIT  = 3'd5
  } msw_op_e;

  // bit positions inside the status word
  localparam int unsigned BIT_PE = 0;
  localparam int unsigned BIT_MP = 1;
  localparam int unsigned BIT_EM = 2;
  localparam int unsigned BIT_TS = 3;
  localparam int unsigned NUM_LIVE_BITS = 4;

  // kind of storage behind each bit
  typedef enum logic [1:0] {
    KIND_STICKY,
    KIND_PLAIN,
    KIND_HWFLAG,
    KIND_RESERVED
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input int unsigned idx);
    if (idx == BIT_PE) return KIND_STICKY;
    if (idx == BIT_MP || idx == BIT_EM) return KIND_PLAIN;
    if (idx == BIT_TS) return KIND_HWFLAG;
    return KIND_RESERVED;
  endfunction

endpackage

// File: rtl/msw_regs.sv
module msw_regs
  import msw_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ts_hw_set,
  input  logic              ts_sw_clr,
  output logic [WORD_W-1:0] word
);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam bit_kind_e KIND = kind_of(b);
    logic bit_q;

    if (KIND == KIND_STICKY) begin : g_sticky
      // only reset can bring it back to zero
      always_ff @(posedge clk) begin
        if (!rst_n)                  bit_q <= 1'b0;
        else if (ld_en && ld_data[b]) bit_q <= 1'b1;
      end
    end else if (KIND == KIND_PLAIN) begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (ld_en) bit_q <= ld_data[b];
      end
    end else if (KIND == KIND_HWFLAG) begin : g_hwflag
      // hardware set has priority over the software clear
      always_ff @(posedge clk) begin
        if (!rst_n)         bit_q <= 1'b0;
        else if (ts_hw_set) bit_q <= 1'b1;
        else if (ts_sw_clr) bit_q <= 1'b0;
      end
    end else begin : g_reserved
      // loads never reach these bits
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_q;
      end
    end

    assign word[b] = bit_q;
  end

endmodule

// File: rtl/msw_priv_gate.sv
module msw_priv_gate
  import msw_pkg::*;
#(
  parameter int unsigned CPL_W = 2
) (
  input  logic             take,
  input  msw_op_e          op,
  input  logic [CPL_W-1:0] cpl,
  input  logic             real_mode,
  output logic             load_ok,
  output logic             clear_ok,
  output logic             priv_fault
);

  logic ring0;
  logic load_allowed;
  logic is_load;
  logic is_clear;

  always_comb begin
    ring0        = (cpl == '0);
    load_allowed = real_mode || ring0;
    is_load      = take && (op == OP_LOAD);
    is_clear     = take && (op == OP_CLRTS);
    load_ok      = is_load && load_allowed;
    clear_ok     = is_clear && ring0;
    priv_fault   = (is_load && !load_allowed) || (is_clear && !ring0);
  end

endmodule

// File: rtl/msw_cop_check.sv
module msw_cop_check
  import msw_pkg::*;
(
  input  logic    take,
  input  msw_op_e op,
  input  logic    mp,
  input  logic    em,
  input  logic    ts,
  output logic    cop_fault
);

  logic esc_trap;
  logic wait_trap;

  always_comb begin
    esc_trap  = (op == OP_ESC) && (em || ts);
    wait_trap = (op == OP_WAIT) && mp && ts;
    cop_fault = take && (esc_trap || wait_trap);
  end

endmodule

// File: rtl/msw_ctrl.sv
module msw_ctrl
  import msw_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned CPL_W    = 2,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned COP_VEC  = 7,
  parameter int unsigned PRIV_VEC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              real_mode,
  input  logic [CPL_W-1:0]  cpl,
  input  logic              ts_set,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data,
  output logic              fault_valid,
  output logic [VEC_W-1:0]  fault_vec,
  output logic [WORD_W-1:0] status_word
);

  localparam logic [VEC_W-1:0] COP_CODE  = VEC_W'(COP_VEC);
  localparam logic [VEC_W-1:0] PRIV_CODE = VEC_W'(PRIV_VEC);

  msw_op_e op;
  logic    take;
  logic    load_ok, clear_ok, priv_fault, cop_fault;
  logic    st_valid_q;
  logic [WORD_W-1:0] st_data_q;
  logic    fault_q;
  logic [VEC_W-1:0] vec_q;

  assign op        = msw_op_e'(cmd_op);
  assign cmd_ready = !st_valid_q;
  assign take      = cmd_valid && cmd_ready;

  msw_priv_gate #(.CPL_W(CPL_W)) i_gate (
    .take       (take),
    .op         (op),
    .cpl        (cpl),
    .real_mode  (real_mode),
    .load_ok    (load_ok),
    .clear_ok   (clear_ok),
    .priv_fault (priv_fault)
  );

  msw_cop_check i_cop (
    .take      (take),
    .op        (op),
    .mp        (status_word[BIT_MP]),
    .em        (status_word[BIT_EM]),
    .ts        (status_word[BIT_TS]),
    .cop_fault (cop_fault)
  );

  msw_regs #(.WORD_W(WORD_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (load_ok),
    .ld_data   (cmd_data),
    .ts_hw_set (ts_set),
    .ts_sw_clr (clear_ok),
    .word      (status_word)
  );

  // store result stream: holds until the consumer takes it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid_q <= 1'b0;
      st_data_q  <= '0;
    end else if (take && op == OP_STORE) begin
      st_valid_q <= 1'b1;
      st_data_q  <= status_word;
    end else if (st_valid_q && st_ready) begin
      st_valid_q <= 1'b0;
    end
  end

  // fault strobe, one cycle per faulting command
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      fault_q <= priv_fault || cop_fault;
      if (priv_fault)     vec_q <= PRIV_CODE;
      else if (cop_fault) vec_q <= COP_CODE;
    end
  end

  assign st_valid    = st_valid_q;
  assign st_data     = st_data_q;
  assign fault_valid = fault_q;
  assign fault_vec   = vec_q;

endmodule

// File: rtl/msw_ctrl_chk.sv
module msw_ctrl_chk
  import msw_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned CPL_W    = 2,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned COP_VEC  = 7,
  parameter int unsigned PRIV_VEC = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              real_mode,
  input logic [CPL_W-1:0]  cpl,
  input logic              ts_set,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [WORD_W-1:0] cmd_data,
  input logic              st_valid,
  input logic              st_ready,
  input logic [WORD_W-1:0] st_data,
  input logic              fault_valid,
  input logic [VEC_W-1:0]  fault_vec,
  input logic [WORD_W-1:0] status_word
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  assert_pe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[BIT_PE] |=> status_word[BIT_PE]);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[WORD_W-1:NUM_LIVE_BITS] == '0);

  assert_refused_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_LOAD && !real_mode && cpl != '0 && !ts_set)
      |=> (fault_valid && fault_vec == VEC_W'(PRIV_VEC) && $stable(status_word)));

  assert_store_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !cmd_ready);

  assert_ts_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ts_set |=> status_word[BIT_TS]);

  assert_esc_em_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_ESC && status_word[BIT_EM])
      |=> (fault_valid && fault_vec == VEC_W'(COP_VEC)));

  assert_wait_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_WAIT && !(status_word[BIT_MP] && status_word[BIT_TS]))
      |=> !fault_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !fault_valid);

endmodule

bind msw_ctrl msw_ctrl_chk i_chk (.*);

// File: tb/test_msw_ctrl.sv
module test_msw_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        real_mode = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        ts_set = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        st_valid;
  logic        st_ready = 1'b1;
  logic [15:0] st_data;
  logic        fault_valid;
  logic [7:0]  fault_vec;
  logic [15:0] status_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  fault_q[$];
  logic [15:0] store_q[$];

  // bench model of the four live bits
  bit m_pe, m_mp, m_em, m_ts;

  always #(CLK_PERIOD/2) clk = ~clk;

  msw_ctrl i_msw_ctrl (
    .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .cpl(cpl),
    .ts_set(ts_set), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .fault_valid(fault_valid),
    .fault_vec(fault_vec), .status_word(status_word)
  );

  function automatic logic [15:0] model_word();
    return {12'h000, m_ts, m_em, m_mp, m_pe};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares results with the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (fault_valid) begin
        if (fault_q.size() == 0) check("R11 unexpected fault", {24'h0, fault_vec}, 32'hFFFF_FFFF);
        else check("R11 fault vector", {24'h0, fault_vec}, {24'h0, fault_q.pop_front()});
      end
      if (st_valid && st_ready) begin
        if (store_q.size() == 0) check("R5 unexpected store", {16'h0, st_data}, 32'hFFFF_FFFF);
        else check("R5 store data", {16'h0, st_data}, {16'h0, store_q.pop_front()});
      end
    end
  end

  // driver: one command, with expectations pushed to the scoreboard
  task automatic issue(input logic [2:0] op, input logic [15:0] d,
                       input logic [1:0] lvl, input logic rm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cpl = lvl; real_mode = rm;
    case (op)
      3'd1: if (rm || lvl == 2'd0) begin
              m_pe = m_pe | d[0]; m_mp = d[1]; m_em = d[2];
            end else fault_q.push_back(8'd13);
      3'd2: store_q.push_back(model_word());
      3'd3: if (lvl == 2'd0) begin
              if (!ts_set) m_ts = 1'b0;
            end else fault_q.push_back(8'd13);
      3'd4: if (m_em || m_ts) fault_q.push_back(8'd7);
      3'd5: if (m_mp && m_ts) fault_q.push_back(8'd7);
      default: ;
    endcase
    if (ts_set) m_ts = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; ts_set = 1'b0;
  endtask

  task automatic pulse_ts();
    @(negedge clk);
    ts_set = 1'b1; m_ts = 1'b1;
    @(negedge clk);
    ts_set = 1'b0;
  endtask

  task automatic check_word(input string req);
    check(req, {16'h0, status_word}, {16'h0, model_word()});
  endtask

  task automatic check_quiet(input string req);
    @(negedge clk);
    check(req, {31'h0, fault_valid}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", {16'h0, status_word}, 32'h0);
    check("R1 st_valid", {31'h0, st_valid}, 32'h0);
    check("R1 fault_valid", {31'h0, fault_valid}, 32'h0);
    check("R1 cmd_ready", {31'h0, cmd_ready}, 32'h1);

    // R4 load refused at level 3 outside real mode
    issue(3'd1, 16'h0007, 2'd3, 1'b0);
    check_word("R4 word unchanged");
    check_quiet("R11 single-cycle fault");

    // R2 load permitted in real mode at level 3
    issue(3'd1, 16'h0003, 2'd3, 1'b1);
    check_word("R2 load real mode");

    // R3 pe sticky, R2 reserved untouched, R6 load does not set TS
    issue(3'd1, 16'hFFFE, 2'd0, 1'b0);
    check_word("R3 pe sticky / R6 ts from load");
    check("R2 reserved bits", {16'h0, status_word & 16'hFFF0}, 32'h0);

    // R5 store at level 3
    issue(3'd2, 16'h0, 2'd3, 1'b0);
    check_quiet("R5 store no fault");

    // R9 escape with emulate set, R10 wait without TS
    issue(3'd4, 16'h0, 2'd3, 1'b0);
    issue(3'd5, 16'h0, 2'd3, 1'b0);
    check_quiet("R10 wait quiet");

    // clear emulate; escape passes
    issue(3'd1, 16'h0002, 2'd0, 1'b0);
    check_word("R2 reload");
    issue(3'd4, 16'h0, 2'd1, 1'b0);
    check_quiet("R9 escape quiet");

    // R6 hardware strobe
    pulse_ts();
    check_word("R6 ts set by strobe");
    issue(3'd4, 16'h0, 2'd0, 1'b0);   // R9 via TS
    issue(3'd5, 16'h0, 2'd0, 1'b0);   // R10 MP and TS
    issue(3'd1, 16'h0000, 2'd0, 1'b0);
    check_word("R6 load keeps ts");
    issue(3'd5, 16'h0, 2'd0, 1'b0);
    check_quiet("R10 wait with TS only");

    // R7 clear at level 2 refused
    issue(3'd3, 16'h0, 2'd2, 1'b0);
    check_word("R7 refused clear");

    // R8 set wins over clear
    @(negedge clk);
    ts_set = 1'b1;
    issue(3'd3, 16'h0, 2'd0, 1'b0);
    check_word("R8 set wins");

    // R7 clear at level 0
    issue(3'd3, 16'h0, 2'd0, 1'b0);
    check_word("R7 clear");
    check("R7 ts low", {31'h0, status_word[3]}, 32'h0);

    // R11 unused op codes
    issue(3'd6, 16'hFFFF, 2'd3, 1'b0);
    issue(3'd0, 16'hFFFF, 2'd0, 1'b1);
    check_word("R11 idle ops");

    // R5 back-pressure
    st_ready = 1'b0;
    issue(3'd2, 16'h0, 2'd2, 1'b1);
    for (int i = 0; i < 3; i++) begin
      check("R5 held valid", {31'h0, st_valid}, 32'h1);
      check("R5 stall", {31'h0, cmd_ready}, 32'h0);
      check("R5 held data", {16'h0, st_data}, 32'h0001);
      @(negedge clk);
    end
    // load offered while stalled must be ignored
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 16'h0006; cpl = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    check_word("R5 ignored while stalled");
    st_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 released", {31'h0, st_valid}, 32'h0);

    repeat (2) @(negedge clk);
    check("R11 pending faults", fault_q.size(), 32'h0);
    check("R5 pending stores", store_q.size(), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule